// File: doc/BRIEF.md
# Level/Edge Trigger Matcher

This block watches a vector of sampled logic-analyser channels and decides when a single-stage trigger condition is met. Each channel carries three configuration bits: whether it takes part, whether it is a level or an edge term, and which polarity it expects. Level terms must hold on the current valid sample. An edge term compares the current valid sample with the previous valid one. All terms are combined with AND. When the condition holds on a valid sample while the block is armed, it raises a one-cycle hit pulse and disarms itself.

Software loads four masks, each one bit per channel. The active mask and the enable mask together select the participating channels. The kind mask picks level (1) or edge (0) for each channel. The polarity mask means high or falling when 1, and low or rising when 0. Only one edge channel is legal. If the masks name more than one, an error output is raised and only the lowest-indexed edge channel is used. A clear strobe re-arms the block after a hit.

Top module: `trig_matcher`

## Requirements
- R1: A participating channel with kind bit 1 and polarity bit 0 is satisfied only when its bit in the valid sample is 0.
- R2: A participating channel with kind bit 1 and polarity bit 1 is satisfied only when its bit in the valid sample is 1.
- R3: A participating channel with kind bit 0 is satisfied when its bit differs between the previous and current valid samples. It must go 0 to 1 when polarity is 0, and 1 to 0 when polarity is 1. It is never satisfied before the first valid sample since reset.
- R4: A channel participates only when both its active bit and its enable bit are 1. The trigger condition is the AND of all participating channel terms.
- R5: With no participating channel, the block fires on the first valid sample seen while armed.
- R6: When more than one participating channel has kind bit 0, cfg_error is 1 from the cycle after the masks are applied. Only the lowest-indexed of those channels acts as the edge term. Otherwise cfg_error is 0.
- R7: trig_hit is a registered pulse, high for exactly the one cycle after the qualifying sample's clock edge. After it fires, no further pulse occurs until the block is re-armed.
- R8: arm_clear re-arms the block. A sample presented in the same cycle as arm_clear cannot fire, but it is still recorded as the previous sample for edge detection.
- R9: A cycle with smp_valid low never fires and does not change the stored previous sample.
- R10: After reset, trig_hit and cfg_error are 0, the block is armed, and no previous sample is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_active | input | NUM_CH | Channels in use |
| cfg_enable | input | NUM_CH | Channels that take part in the trigger |
| cfg_level | input | NUM_CH | 1 = level term, 0 = edge term |
| cfg_polarity | input | NUM_CH | 1 = high/falling, 0 = low/rising |
| smp_data | input | NUM_CH | Sampled channel values |
| smp_valid | input | 1 | smp_data holds a new sample |
| arm_clear | input | 1 | Re-arm strobe |
| trig_hit | output | 1 | One-cycle trigger pulse |
| cfg_error | output | 1 | More than one edge channel configured |

## Verification
Every channel is tried on its own as a low level, a high level, a rising edge and a falling edge. Directed non-matching and matching samples are followed by pseudo-random ones, which shows that index and polarity decode cleanly per channel. A four-channel mixed-polarity level condition is swept over all sixteen nibble values, with and without some channels masked inactive, to separate the AND combination from the active gating. Two-edge configurations show which edge channel wins. Sequences with idle cycles, the empty condition, and a clear coinciding with a qualifying sample check how history and arming behave. Long pseudo-random runs over random configurations compare every cycle with an arithmetic model.

// File: rtl/tmatch_pkg.sv
package tmatch_pkg;
  typedef enum logic [0:0] {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_kind_e;

  localparam int unsigned TM_DEF_CH = 16;
endpackage

// File: rtl/tm_level_match.sv
module tm_level_match #(
  parameter int unsigned NUM_CH = 16
) (
  input  logic [NUM_CH-1:0] lvl_mask,
  input  logic [NUM_CH-1:0] lvl_pol,
  input  logic [NUM_CH-1:0] smp,
  output logic              match
);
  logic [NUM_CH-1:0] ch_ok;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign ch_ok[i] = ~lvl_mask[i] | (smp[i] == lvl_pol[i]);
  end

  assign match = &ch_ok;
endmodule

// File: rtl/tm_edge_pick.sv
module tm_edge_pick #(
  parameter int unsigned NUM_CH = 16,
  localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] edge_mask,
  output logic              found,
  output logic [IDX_W-1:0]  idx,
  output logic              multi
);
  logic [NUM_CH:0]   seen;
  logic [NUM_CH-1:0] first;
  logic [NUM_CH-1:0] extra;

  assign seen[0] = 1'b0;
  for (genvar i = 0; i < NUM_CH; i++) begin : g_chain
    assign first[i]  = edge_mask[i] & ~seen[i];
    assign extra[i]  = edge_mask[i] & seen[i];
    assign seen[i+1] = seen[i] | edge_mask[i];
  end

  assign found = seen[NUM_CH];
  assign multi = |extra;

  always_comb begin
    idx = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (first[i]) idx = i[IDX_W-1:0];
    end
  end

  // R6: the chain selects no more than one edge channel
  always_comb begin
    p_single_pick_r6: assert ($onehot0(first));
  end
endmodule

// File: rtl/tm_edge_match.sv
module tm_edge_match
  import tmatch_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              found,
  input  logic [IDX_W-1:0]  idx,
  input  edge_kind_e        kind,
  input  logic [NUM_CH-1:0] prev,
  input  logic              prev_valid,
  input  logic [NUM_CH-1:0] cur,
  output logic              match
);
  logic bit_now;
  logic bit_old;
  logic seen_edge;

  assign bit_now   = cur[idx];
  assign bit_old   = prev[idx];
  assign seen_edge = prev_valid & (bit_now != bit_old) &
                     (bit_now == (kind == EDGE_RISE));
  assign match     = ~found | seen_edge;
endmodule

// File: rtl/trig_matcher.sv
module trig_matcher
  import tmatch_pkg::*;
#(
  parameter int unsigned NUM_CH = TM_DEF_CH,
  localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] cfg_active,
  input  logic [NUM_CH-1:0] cfg_enable,
  input  logic [NUM_CH-1:0] cfg_level,
  input  logic [NUM_CH-1:0] cfg_polarity,
  input  logic [NUM_CH-1:0] smp_data,
  input  logic              smp_valid,
  input  logic              arm_clear,
  output logic              trig_hit,
  output logic              cfg_error
);
  logic [NUM_CH-1:0] part_mask;
  logic [NUM_CH-1:0] lvl_mask;
  logic [NUM_CH-1:0] edge_mask;
  logic              lvl_ok;
  logic              edge_found;
  logic [IDX_W-1:0]  edge_idx;
  logic              edge_multi;
  edge_kind_e        edge_kind;
  logic              edge_ok;
  logic              cond;
  logic [NUM_CH-1:0] prev_smp;
  logic              prev_valid;
  logic              armed;

  assign part_mask = cfg_active & cfg_enable;
  assign lvl_mask  = part_mask & cfg_level;
  assign edge_mask = part_mask & ~cfg_level;

  tm_level_match #(.NUM_CH(NUM_CH)) u_level (
    .lvl_mask (lvl_mask),
    .lvl_pol  (cfg_polarity),
    .smp      (smp_data),
    .match    (lvl_ok)
  );

  tm_edge_pick #(.NUM_CH(NUM_CH)) u_pick (
    .edge_mask (edge_mask),
    .found     (edge_found),
    .idx       (edge_idx),
    .multi     (edge_multi)
  );

  assign edge_kind = cfg_polarity[edge_idx] ? EDGE_FALL : EDGE_RISE;

  tm_edge_match #(.NUM_CH(NUM_CH)) u_edge (
    .found      (edge_found),
    .idx        (edge_idx),
    .kind       (edge_kind),
    .prev       (prev_smp),
    .prev_valid (prev_valid),
    .cur        (smp_data),
    .match      (edge_ok)
  );

  assign cond = lvl_ok & edge_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed      <= 1'b1;
      trig_hit   <= 1'b0;
      cfg_error  <= 1'b0;
      prev_smp   <= '0;
      prev_valid <= 1'b0;
    end else begin
      trig_hit  <= 1'b0;
      cfg_error <= edge_multi;
      if (smp_valid) begin
        prev_smp   <= smp_data;
        prev_valid <= 1'b1;
      end
      if (arm_clear) begin
        armed <= 1'b1;
      end else if (smp_valid && armed && cond) begin
        trig_hit <= 1'b1;
        armed    <= 1'b0;
      end
    end
  end

  // R7: a pulse is never followed directly by another
  p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    trig_hit |=> !trig_hit);

  // R9: a hit always stems from a valid sample
  p_hit_from_valid_r9: assert property (@(posedge clk) disable iff (rst)
    trig_hit |-> $past(smp_valid));

  // R8: a clear cycle cannot produce a hit
  p_clear_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    arm_clear |=> !trig_hit);

  // R1, R2: every level term agreed with the sample that fired
  p_level_agree_r1: assert property (@(posedge clk) disable iff (rst)
    trig_hit |-> ($past((smp_data ^ cfg_polarity) & lvl_mask) == '0));

  // R3: an edge term needs stored history
  p_edge_history_r3: assert property (@(posedge clk) disable iff (rst)
    (trig_hit && $past(edge_found)) |-> $past(prev_valid));
endmodule

// File: tb/trig_matcher_tb.sv
module trig_matcher_tb;
  localparam int NCH = 16;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0] cfg_active = '0, cfg_enable = '0, cfg_level = '0, cfg_polarity = '0;
  logic [NCH-1:0] smp_data = '0;
  logic smp_valid = 1'b0, arm_clear = 1'b0;
  logic trig_hit, cfg_error;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  logic [NCH-1:0] m_prev = '0;
  logic m_pv = 1'b0;
  logic m_armed = 1'b1;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_matcher #(.NUM_CH(NCH)) u_dut (
    .clk(clk), .rst(rst),
    .cfg_active(cfg_active), .cfg_enable(cfg_enable),
    .cfg_level(cfg_level), .cfg_polarity(cfg_polarity),
    .smp_data(smp_data), .smp_valid(smp_valid), .arm_clear(arm_clear),
    .trig_hit(trig_hit), .cfg_error(cfg_error)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic int edge_count();
    int n = 0;
    for (int i = 0; i < NCH; i++)
      if (cfg_active[i] && cfg_enable[i] && !cfg_level[i]) n++;
    return n;
  endfunction

  function automatic logic model_cond(input logic [NCH-1:0] d);
    logic ok = 1'b1;
    bit got_edge = 0;
    for (int i = 0; i < NCH; i++) begin
      if (cfg_active[i] && cfg_enable[i]) begin
        if (cfg_level[i]) begin
          if (d[i] != cfg_polarity[i]) ok = 1'b0;
        end else if (!got_edge) begin
          got_edge = 1;
          if (!m_pv) ok = 1'b0;
          else if (cfg_polarity[i] && !(m_prev[i] && !d[i])) ok = 1'b0;
          else if (!cfg_polarity[i] && !(!m_prev[i] && d[i])) ok = 1'b0;
        end
      end
    end
    return ok;
  endfunction

  task automatic step(input logic [NCH-1:0] d, input logic v, input logic c, input string tag);
    logic e = 1'b0;
    smp_data = d; smp_valid = v; arm_clear = c;
    if (c) m_armed = 1'b1;
    else if (v && m_armed && model_cond(d)) begin e = 1'b1; m_armed = 1'b0; end
    if (v) begin m_prev = d; m_pv = 1'b1; end
    @(posedge clk); @(negedge clk);
    check(trig_hit, e, tag);
    check(cfg_error, edge_count() > 1, "R6 error flag");
  endtask

  task automatic set_cfg(input logic [NCH-1:0] a, en, lv, po);
    cfg_active = a; cfg_enable = en; cfg_level = lv; cfg_polarity = po;
  endtask

  task automatic rand_steps(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      lfsr = lfsr_next(lfsr);
      step(lfsr, lfsr[3] | lfsr[7], (lfsr[11:9] == 3'b101), tag);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL R7 watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    check(trig_hit, 1'b0, "R10 hit after reset");
    check(cfg_error, 1'b0, "R10 error after reset");

    // R5 / R9 / R7 / R8 with no participating channels
    step(16'h1234, 1'b0, 1'b0, "R9 invalid sample");
    step(16'h1234, 1'b1, 1'b0, "R5 first valid fires");
    step(16'h0000, 1'b1, 1'b0, "R7 once per arm");
    step(16'h0000, 1'b1, 1'b1, "R8 clear blocks fire");
    step(16'hFFFF, 1'b1, 1'b0, "R5 fires after rearm");

    // R1 / R2 per-channel level sweep
    for (int c = 0; c < NCH; c++) begin
      for (int p = 0; p < 2; p++) begin
        set_cfg(16'hFFFF, 16'h1 << c, 16'hFFFF, p ? (16'h1 << c) : 16'h0);
        step('0, 1'b0, 1'b1, "R8 rearm");
        step(p ? ~(16'h1 << c) : (16'h1 << c), 1'b1, 1'b0, p ? "R2 mismatch" : "R1 mismatch");
        step(p ? (16'h1 << c) : ~(16'h1 << c), 1'b1, 1'b0, p ? "R2 match" : "R1 match");
        step('0, 1'b0, 1'b1, "R8 rearm");
        rand_steps(6, p ? "R2 random" : "R1 random");
      end
    end

    // R3 per-channel edge sweep
    for (int c = 0; c < NCH; c++) begin
      for (int p = 0; p < 2; p++) begin
        set_cfg(16'hFFFF, 16'h1 << c, 16'h0, p ? (16'h1 << c) : 16'h0);
        step('0, 1'b0, 1'b1, "R8 rearm");
        step(p ? 16'h0 : 16'hFFFF, 1'b1, 1'b0, "R3 wrong direction setup");
        step(p ? 16'hFFFF : 16'h0, 1'b1, 1'b0, "R3 wrong direction");
        step(16'h0, 1'b0, 1'b0, "R9 gap keeps history");
        step(p ? 16'h0 : 16'hFFFF, 1'b1, 1'b0, "R3 edge across gap");
        rand_steps(6, "R3 random");
      end
    end

    // R4 AND over mixed-polarity levels, with and without inactive channels
    for (int a = 0; a < 2; a++) begin
      set_cfg(a ? 16'h0003 : 16'hFFFF, 16'h000F, 16'h000F, 16'h0005);
      for (int v = 0; v < 16; v++) begin
        step('0, 1'b0, 1'b1, "R8 rearm");
        step(v[15:0], 1'b1, 1'b0, a ? "R4 inactive ignored" : "R4 AND sweep");
      end
    end

    // R6 two edge channels: lowest index wins
    set_cfg(16'hFFFF, 16'h0088, 16'h0000, 16'h0000);
    step(16'h0000, 1'b1, 1'b1, "R6 setup");
    step(16'h0080, 1'b1, 1'b0, "R6 higher edge ignored");
    step(16'h0088, 1'b1, 1'b0, "R6 lowest edge fires");
    set_cfg(16'hFFFF, 16'h0088, 16'h0000, 16'h0008);
    step(16'h0008, 1'b1, 1'b1, "R6 falling setup");
    step(16'h0000, 1'b1, 1'b0, "R6 lowest falling fires");

    // R8 clear coinciding with qualifying edge; history still kept
    set_cfg(16'hFFFF, 16'h0001, 16'h0000, 16'h0000);
    step(16'h0000, 1'b1, 1'b0, "R8 setup");
    step(16'h0001, 1'b1, 1'b1, "R8 clear same cycle");
    step(16'h0001, 1'b1, 1'b0, "R8 no edge after held high");
    step(16'h0000, 1'b1, 1'b0, "R8 low");
    step(16'h0001, 1'b1, 1'b0, "R8 fires after rearm");

    // R4 random configurations
    for (int r = 0; r < 40; r++) begin
      lfsr = lfsr_next(lfsr); cfg_active = lfsr | 16'hF0F0;
      lfsr = lfsr_next(lfsr); cfg_enable = lfsr & 16'h0421;
      lfsr = lfsr_next(lfsr); cfg_level = lfsr;
      lfsr = lfsr_next(lfsr); cfg_polarity = lfsr;
      step('0, 1'b0, 1'b1, "R8 rearm");
      rand_steps(60, "R4 random config");
    end

    done = 1;
    finish_run();
  end
endmodule